// File: doc/BRIEF.md
# Five-Source Priority Interrupt Unit

This unit sits beside a processor's instruction sequencer and decides, once per instruction, whether an interrupt is taken and which one. Five request lines feed it: one non-maskable source, one edge-triggered maskable source, two level-sensitive maskable sources and one general maskable request. The general request has no fixed service address. The requesting device supplies that address, so the unit starts an acknowledge cycle for it instead of producing a vector.

The sequencer pulses a strobe during the second T-state of the final machine cycle of each instruction. Request lines are weighed only at that strobe. A winning vectored source produces a one-cycle vector-valid pulse carrying its fixed address. A winning general request produces a one-cycle acknowledge pulse instead.

Commands from the instruction decoder control acceptance:
- An enable command sets the global enable flag, and a disable command clears it.
- A set-mask command writes the three mask bits and can also flush the edge latch.
- A read command returns the mask, the global enable flag and the pending state.

Top module: `ipu_top`

## Requirements
- R1: After reset, vec_valid_o, vec_addr_o, ack_o and rd_valid_o are 0, the three mask bits are all 1 (all maskable sources blocked) and the global enable flag is 0.
- R2: When several sources qualify at a strobe, the one taken follows the order, from highest to lowest: nmi, edge source, high-level source, low-level source, general request. The vector addresses are 0x0024 for nmi, 0x003C for the edge source, 0x0034 for the high-level source and 0x002C for the low-level source.
- R3: A maskable source qualifies only while the global enable flag is 1 and its mask bit is 0. The mask bits are: bit 2 for the edge source, bit 1 for the high-level source and bit 0 for the low-level source. The general request has no mask bit and needs only the enable flag.
- R4: When the general request is taken, ack_o is 1 for one cycle, the cycle after the strobe. In that cycle vec_valid_o is 0.
- R5: Requests are weighed only in a cycle where sample_i is 1. A result appears the next cycle as a one-cycle pulse. With sample_i low, no output pulse occurs whatever the request lines do.
- R6: Taking any maskable source clears the global enable flag. cmd_en_i sets the flag and cmd_dis_i clears it, each taking effect at the next clock edge.
- R7: A rising edge on req_edge_i sets an edge latch whatever the mask, provided the edge happens at least one clock before the strobe. The latch stays set until the edge source is taken, or until a set-mask command arrives with edge_flush_i at 1. A set-mask command with edge_flush_i at 0 leaves the latch unchanged.
- R8: The two level sources are not stored. A level that rose and fell before the strobe is not taken.
- R9: nmi is taken regardless of the enable flag and the mask. It is taken when req_nmi_i is 1 at the strobe and a rising edge has been seen since it was last taken; a level held high from reset counts as a rising edge. Taking nmi leaves the enable flag unchanged.
- R10: cmd_rd_i produces rd_valid_o for one cycle on the next cycle. In that cycle rd_data_o reads: bit 6 is the edge latch, bit 5 is req_lvl_hi_i, bit 4 is req_lvl_lo_i, bit 3 is the enable flag and bits 2:0 are the mask. Each value is as it stood in the command cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_i | input | 1 | Sequencer strobe marking the decision point of an instruction |
| req_nmi_i | input | 1 | Non-maskable request |
| req_edge_i | input | 1 | Edge-triggered maskable request |
| req_lvl_hi_i | input | 1 | Level-sensitive maskable request, higher rank |
| req_lvl_lo_i | input | 1 | Level-sensitive maskable request, lower rank |
| req_ext_i | input | 1 | General maskable request, address supplied by device |
| cmd_en_i | input | 1 | Set the global enable flag |
| cmd_dis_i | input | 1 | Clear the global enable flag |
| cmd_setmask_i | input | 1 | Write mask_wdata_i into the mask |
| mask_wdata_i | input | 3 | New mask bits (1 = blocked) |
| edge_flush_i | input | 1 | With cmd_setmask_i, clear the edge latch |
| cmd_rd_i | input | 1 | Request a status read |
| vec_valid_o | output | 1 | A vectored source was taken |
| vec_addr_o | output | ADDR_W | Fixed service address of the taken source |
| ack_o | output | 1 | Acknowledge cycle for the general request |
| rd_valid_o | output | 1 | rd_data_o is valid |
| rd_data_o | output | 7 | Status read result |

## Verification
The bench sweeps every combination of enable flag, mask, level inputs, general request and edge latch. Against that sweep, a wrong priority chain or vector table yields a wrong address, and a mask bit wired to the wrong source passes requests that should be blocked. The bench also checks that the edge latch survives a mask write without flush, so a design that clears it on any mask write would lose the edge. A level that drops before the strobe must not be taken, which catches a design that stores level requests. The nmi cases check that a held level is not taken twice, that the source wins over a pending edge without touching the enable flag, and that a line held high through reset is still taken.

// File: rtl/ipu_pkg.sv
package ipu_pkg;

    // Source indices; a lower index wins arbitration.
    localparam int N_SRC    = 5;
    localparam int IDX_NMI  = 0;
    localparam int IDX_EDGE = 1;
    localparam int IDX_HI   = 2;
    localparam int IDX_LO   = 3;
    localparam int IDX_EXT  = 4;

    // Mask bit positions inside the mask field.
    localparam int MASK_W   = 3;
    localparam int MB_LO    = 0;
    localparam int MB_HI    = 1;
    localparam int MB_EDGE  = 2;

    localparam logic [15:0] VEC_NMI  = 16'h0024;
    localparam logic [15:0] VEC_EDGE = 16'h003C;
    localparam logic [15:0] VEC_HI   = 16'h0034;
    localparam logic [15:0] VEC_LO   = 16'h002C;

    typedef struct packed {
        logic              edge_pend;
        logic              lvl_hi;
        logic              lvl_lo;
        logic              ien;
        logic [MASK_W-1:0] mask;
    } rdback_t;

    function automatic logic [15:0] vec_of(input int idx);
        case (idx)
            IDX_NMI:  return VEC_NMI;
            IDX_EDGE: return VEC_EDGE;
            IDX_HI:   return VEC_HI;
            IDX_LO:   return VEC_LO;
            default:  return 16'h0000;
        endcase
    endfunction

endpackage

// File: rtl/ipu_edge_capture.sv
module ipu_edge_capture (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    input  logic clr_i,
    output logic pend_o
);
    typedef struct packed {
        logic prev;
        logic pend;
    } cap_t;

    cap_t c_d, c_q;

    // A new rising edge wins over a clear in the same cycle.
    always_comb begin
        c_d      = c_q;
        c_d.prev = level_i;
        if (clr_i)
            c_d.pend = 1'b0;
        if (level_i && !c_q.prev)
            c_d.pend = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign pend_o = c_q.pend;
endmodule

// File: rtl/ipu_arbiter.sv
module ipu_arbiter #(
    parameter int N = 5
) (
    input  logic [N-1:0] req_i,
    output logic [N-1:0] grant_o,
    output logic         any_o
);
    for (genvar i = 0; i < N; i++) begin : g_pri
        if (i == 0) begin : g_top
            assign grant_o[i] = req_i[i];
        end else begin : g_rest
            assign grant_o[i] = req_i[i] & ~(|req_i[i-1:0]);
        end
    end

    assign any_o = |req_i;
endmodule

// File: rtl/ipu_vector_map.sv
module ipu_vector_map
    import ipu_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic [N_SRC-1:0]  grant_i,
    output logic [ADDR_W-1:0] addr_o
);
    logic [ADDR_W-1:0] part [N_SRC];

    for (genvar i = 0; i < N_SRC; i++) begin : g_map
        localparam logic [15:0] VEC = vec_of(i);
        assign part[i] = grant_i[i] ? ADDR_W'(VEC) : '0;
    end

    always_comb begin
        addr_o = '0;
        for (int k = 0; k < N_SRC; k++)
            addr_o = addr_o | part[k];
    end
endmodule

// File: rtl/ipu_top.sv
module ipu_top
    import ipu_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sample_i,
    input  logic                  req_nmi_i,
    input  logic                  req_edge_i,
    input  logic                  req_lvl_hi_i,
    input  logic                  req_lvl_lo_i,
    input  logic                  req_ext_i,
    input  logic                  cmd_en_i,
    input  logic                  cmd_dis_i,
    input  logic                  cmd_setmask_i,
    input  logic [MASK_W-1:0]     mask_wdata_i,
    input  logic                  edge_flush_i,
    input  logic                  cmd_rd_i,
    output logic                  vec_valid_o,
    output logic [ADDR_W-1:0]     vec_addr_o,
    output logic                  ack_o,
    output logic                  rd_valid_o,
    output logic [$bits(rdback_t)-1:0] rd_data_o
);
    localparam int RD_W = $bits(rdback_t);

    typedef struct packed {
        logic              ien;
        logic [MASK_W-1:0] mask;
        logic              vec_valid;
        logic [ADDR_W-1:0] vec_addr;
        logic              ack;
        logic              rd_valid;
        logic [RD_W-1:0]   rd_data;
    } state_t;

    state_t s_d, s_q;

    logic             nmi_seen, edge_pend;
    logic             nmi_take, edge_clr, maskable_take, any_grant;
    logic [N_SRC-1:0] cand, grant;
    logic [ADDR_W-1:0] map_addr;
    logic             ien_now;
    rdback_t          rd_now;

    ipu_edge_capture u_nmi_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (req_nmi_i),
        .clr_i   (nmi_take),
        .pend_o  (nmi_seen)
    );

    ipu_edge_capture u_edge_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (req_edge_i),
        .clr_i   (edge_clr),
        .pend_o  (edge_pend)
    );

    always_comb begin
        cand           = '0;
        cand[IDX_NMI]  = sample_i & req_nmi_i & nmi_seen;
        cand[IDX_EDGE] = sample_i & s_q.ien & edge_pend    & ~s_q.mask[MB_EDGE];
        cand[IDX_HI]   = sample_i & s_q.ien & req_lvl_hi_i & ~s_q.mask[MB_HI];
        cand[IDX_LO]   = sample_i & s_q.ien & req_lvl_lo_i & ~s_q.mask[MB_LO];
        cand[IDX_EXT]  = sample_i & s_q.ien & req_ext_i;
    end

    ipu_arbiter #(.N(N_SRC)) u_arb (
        .req_i   (cand),
        .grant_o (grant),
        .any_o   (any_grant)
    );

    ipu_vector_map #(.ADDR_W(ADDR_W)) u_map (
        .grant_i (grant),
        .addr_o  (map_addr)
    );

    assign nmi_take      = grant[IDX_NMI];
    assign maskable_take = |grant[N_SRC-1:1];
    assign edge_clr      = grant[IDX_EDGE] | (cmd_setmask_i & edge_flush_i);

    always_comb begin
        rd_now.edge_pend = edge_pend;
        rd_now.lvl_hi    = req_lvl_hi_i;
        rd_now.lvl_lo    = req_lvl_lo_i;
        rd_now.ien       = s_q.ien;
        rd_now.mask      = s_q.mask;
    end

    always_comb begin
        s_d           = s_q;
        s_d.vec_valid = any_grant & ~grant[IDX_EXT];
        s_d.vec_addr  = map_addr;
        s_d.ack       = grant[IDX_EXT];
        if (maskable_take) s_d.ien = 1'b0;
        if (cmd_dis_i)     s_d.ien = 1'b0;
        if (cmd_en_i)      s_d.ien = 1'b1;
        if (cmd_setmask_i) s_d.mask = mask_wdata_i;
        s_d.rd_valid  = cmd_rd_i;
        if (cmd_rd_i)      s_d.rd_data = rd_now;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.mask <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    assign ien_now     = s_q.ien;
    assign vec_valid_o = s_q.vec_valid;
    assign vec_addr_o  = s_q.vec_addr;
    assign ack_o       = s_q.ack;
    assign rd_valid_o  = s_q.rd_valid;
    assign rd_data_o   = s_q.rd_data;
endmodule

// File: rtl/ipu_checker.sv
module ipu_checker
    import ipu_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sample_i,
    input logic              req_nmi_i,
    input logic              cmd_en_i,
    input logic              cmd_rd_i,
    input logic              ien_now,
    input logic              vec_valid_o,
    input logic [ADDR_W-1:0] vec_addr_o,
    input logic              ack_o,
    input logic              rd_valid_o
);
    p_pulse_after_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid_o || ack_o) |-> $past(sample_i));

    p_vector_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid_o |-> (vec_addr_o == ADDR_W'(VEC_NMI)  || vec_addr_o == ADDR_W'(VEC_EDGE) ||
                         vec_addr_o == ADDR_W'(VEC_HI)   || vec_addr_o == ADDR_W'(VEC_LO)));

    p_ack_alone_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> !vec_valid_o);

    p_disabled_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_i && !ien_now && !req_nmi_i) |=> (!ack_o && !vec_valid_o));

    p_take_drops_enable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((ack_o || (vec_valid_o && vec_addr_o != ADDR_W'(VEC_NMI))) && !$past(cmd_en_i))
            |-> !ien_now);

    p_read_follows_cmd_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o |-> $past(cmd_rd_i));
endmodule

bind ipu_top ipu_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sample_i    (sample_i),
    .req_nmi_i   (req_nmi_i),
    .cmd_en_i    (cmd_en_i),
    .cmd_rd_i    (cmd_rd_i),
    .ien_now     (ien_now),
    .vec_valid_o (vec_valid_o),
    .vec_addr_o  (vec_addr_o),
    .ack_o       (ack_o),
    .rd_valid_o  (rd_valid_o)
);

// File: tb/ipu_top_bench.sv
`timescale 1ns/1ps
module ipu_top_bench;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       sample_i, req_nmi_i, req_edge_i, req_lvl_hi_i, req_lvl_lo_i, req_ext_i;
    logic       cmd_en_i, cmd_dis_i, cmd_setmask_i, edge_flush_i, cmd_rd_i;
    logic [2:0] mask_wdata_i;
    logic       vec_valid_o, ack_o, rd_valid_o;
    logic [15:0] vec_addr_o;
    logic [6:0] rd_data_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    ipu_top u_ipu_top (
        .clk(clk), .rst_n(rst_n), .sample_i(sample_i), .req_nmi_i(req_nmi_i),
        .req_edge_i(req_edge_i), .req_lvl_hi_i(req_lvl_hi_i), .req_lvl_lo_i(req_lvl_lo_i),
        .req_ext_i(req_ext_i), .cmd_en_i(cmd_en_i), .cmd_dis_i(cmd_dis_i),
        .cmd_setmask_i(cmd_setmask_i), .mask_wdata_i(mask_wdata_i), .edge_flush_i(edge_flush_i),
        .cmd_rd_i(cmd_rd_i), .vec_valid_o(vec_valid_o), .vec_addr_o(vec_addr_o),
        .ack_o(ack_o), .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic setup(input bit en, input logic [2:0] m);
        cmd_setmask_i = 1'b1; mask_wdata_i = m; edge_flush_i = 1'b1;
        cmd_en_i = en; cmd_dis_i = !en;
        @(negedge clk);
        cmd_setmask_i = 1'b0; edge_flush_i = 1'b0; cmd_en_i = 1'b0; cmd_dis_i = 1'b0;
    endtask

    task automatic pulse_edge();
        req_edge_i = 1'b1;
        @(negedge clk);
        req_edge_i = 1'b0;
        @(negedge clk);
    endtask

    task automatic read_chk(input string tag, input logic [6:0] exp);
        cmd_rd_i = 1'b1;
        @(negedge clk);
        cmd_rd_i = 1'b0;
        chk({tag, " rd_valid"}, 32'(rd_valid_o), 32'd1);
        chk({tag, " rd_data"}, 32'(rd_data_o), 32'(exp));
    endtask

    task automatic sample_chk(input string tag, input bit ev, input logic [15:0] ea, input bit eack);
        sample_i = 1'b1;
        @(negedge clk);
        sample_i = 1'b0;
        chk({tag, " vec_valid"}, 32'(vec_valid_o), 32'(ev));
        if (ev) chk({tag, " vec_addr"}, 32'(vec_addr_o), 32'(ea));
        chk({tag, " ack"}, 32'(ack_o), 32'(eack));
        @(negedge clk);
        chk({tag, " R5 pulse ends"}, 32'(vec_valid_o | ack_o), 32'd0);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; sample_i = 0; req_nmi_i = 1'b1; req_edge_i = 0; req_lvl_hi_i = 0;
        req_lvl_lo_i = 0; req_ext_i = 0; cmd_en_i = 0; cmd_dis_i = 0; cmd_setmask_i = 0;
        mask_wdata_i = 3'b000; edge_flush_i = 0; cmd_rd_i = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 vec_valid", 32'(vec_valid_o), 32'd0);
        chk("R1 ack", 32'(ack_o), 32'd0);
        chk("R1 rd_valid", 32'(rd_valid_o), 32'd0);
        read_chk("R1 mask/enable", 7'h07);

        // R9: nmi held through reset is taken, with enable off
        sample_chk("R9 nmi after reset", 1, 16'h0024, 0);
        sample_chk("R9 no second take without edge", 0, 16'h0, 0);
        req_nmi_i = 0; @(negedge clk);
        req_nmi_i = 1; @(negedge clk);
        sample_chk("R9 nmi new edge", 1, 16'h0024, 0);
        read_chk("R9 enable untouched off", 7'h07);

        // R2/R9: nmi beats pending edge and leaves enable set
        setup(1, 3'b000);
        pulse_edge();
        req_nmi_i = 0; @(negedge clk);
        req_nmi_i = 1; @(negedge clk);
        sample_chk("R2 nmi over edge", 1, 16'h0024, 0);
        read_chk("R9 enable kept", 7'h48);
        sample_chk("R2 edge next", 1, 16'h003C, 0);
        read_chk("R6 R7 after edge take", 7'h00);
        req_nmi_i = 0; @(negedge clk);

        // R6: enable command re-arms
        cmd_en_i = 1; @(negedge clk); cmd_en_i = 0;
        read_chk("R6 enable cmd", 7'h08);

        // R5: no strobe, no result
        req_lvl_hi_i = 1; req_ext_i = 1;
        repeat (4) begin
            @(negedge clk);
            chk("R5 no strobe", 32'(vec_valid_o | ack_o), 32'd0);
        end
        req_lvl_hi_i = 0; req_ext_i = 0;

        // R8: level gone before strobe is not taken
        req_lvl_hi_i = 1; @(negedge clk);
        req_lvl_hi_i = 0; @(negedge clk);
        sample_chk("R8 level not stored", 0, 16'h0, 0);

        // R7: mask write without flush keeps latch
        setup(0, 3'b111);
        pulse_edge();
        mask_wdata_i = 3'b000; cmd_setmask_i = 1; edge_flush_i = 0;
        @(negedge clk);
        cmd_setmask_i = 0;
        read_chk("R7 latch kept", 7'h40);
        cmd_en_i = 1; @(negedge clk); cmd_en_i = 0;
        sample_chk("R7 latched edge taken", 1, 16'h003C, 0);

        // Sweep: R2 R3 R4 R6 R7 R10
        for (int c = 0; c < 256; c++) begin
            bit en, hi, lo, ext, ep, t_edge, t_mask, ev, eack;
            logic [2:0] m;
            logic [15:0] ea;
            en = c[7]; m = c[6:4]; hi = c[3]; lo = c[2]; ext = c[1]; ep = c[0];
            setup(en, m);
            if (ep) pulse_edge();
            req_lvl_hi_i = hi; req_lvl_lo_i = lo; req_ext_i = ext;
            read_chk("R10 sweep before", {ep, hi, lo, en, m});
            ev = 0; eack = 0; ea = 16'h0; t_edge = 0;
            if (en) begin
                if (ep && !m[2])      begin ev = 1; ea = 16'h003C; t_edge = 1; end
                else if (hi && !m[1]) begin ev = 1; ea = 16'h0034; end
                else if (lo && !m[0]) begin ev = 1; ea = 16'h002C; end
                else if (ext)         eack = 1;
            end
            t_mask = ev | eack;
            sample_chk("R2 R3 R4 sweep", ev, ea, eack);
            read_chk("R6 R7 sweep after", {ep & !t_edge, hi, lo, en & !t_mask, m});
            req_lvl_hi_i = 0; req_lvl_lo_i = 0; req_ext_i = 0;
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule